// File: doc/BRIEF.md
# Acknowledge-Stretched External Bus Sequencer

This block turns a single internal read or write request into one external bus cycle. The cycle is made of eight fixed phases, P0 to P7. The address strobe, data strobe, read/not-write line and data-bus output enable each change on a fixed phase. Every phase lasts the same number of clocks, set by a static length input. The sequencer holds phase P4 until a transfer acknowledge from the peripheral has passed through a synchronizer. While it waits, it adds whole extra phase periods.

The internal side offers a request, a write flag, an address and write data. The request is accepted only while the sequencer is idle. When the cycle ends, the sequencer returns a one-clock completion pulse. For a read, the captured data is presented with that pulse. Strobes and direction are active high: `rd_nwr_o` high means read or idle, and low means write.

Top module: `hsk_bus_master`

## Requirements
- R1: After reset, `addr_stb_o`, `data_stb_o`, `data_oe_o` and `done_o` are low and `rd_nwr_o` is high.
- R2: A request seen at clock edge A (while idle) starts P0 at A. Every phase lasts L = `phase_len_i`+1 clocks, so Pn without waits starts at edge A+n·L.
- R3: From P1 through P7, `addr_o` carries the address captured with the request, and it is stable while `addr_stb_o` is high.
- R4: `addr_stb_o` is high exactly in P2..P6, and `data_stb_o` is high exactly in P4..P6. Both are low in P7, and `data_stb_o` is never high without `addr_stb_o`.
- R5: For a write, `rd_nwr_o` is low exactly in P2..P7. For a read, it stays high throughout.
- R6: For a write, `data_oe_o` is high exactly in P3..P7, with `data_o` equal to the captured write data. For a read, `data_oe_o` never rises.
- R7: `ack_i` goes through a two-flop synchronizer. If P4 starts at edge E, it ends at the first edge E+k·L (k≥1) for which `ack_i` was captured high by the first synchronizer flop at edge E+k·L−3 or earlier. Each refused exit adds one full wait period of L clocks.
- R8: For a read, `data_i` is captured on the edge that enters P7. Later changes of `data_i` do not affect `rdata_o`.
- R9: `done_o` is high for exactly one clock: the first idle clock after P7. `rdata_o` holds the read data then and afterwards.
- R10: A request raised while a cycle is in progress is ignored. It does not change the address of the running cycle, and it does not start another cycle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a bus cycle (taken only while idle) |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Cycle address |
| wdata_i | input | DATA_W | Write data |
| phase_len_i | input | LEN_W | Clocks per phase minus one (static) |
| ack_i | input | 1 | Asynchronous transfer acknowledge, active high |
| data_i | input | DATA_W | Data bus input |
| addr_o | output | ADDR_W | Address bus |
| data_o | output | DATA_W | Data bus output value |
| data_oe_o | output | 1 | Data bus output enable |
| addr_stb_o | output | 1 | Address strobe |
| data_stb_o | output | 1 | Data strobe |
| rd_nwr_o | output | 1 | 1 = read/idle, 0 = write |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Captured read data |

## Verification
The assertions assume that `phase_len_i` changes only while the block is idle. They also assume that `ack_i` drops only after the data strobe has fallen, so a stale acknowledge never reaches the next cycle's P4. The bench changes the length only between cycles, with idle clocks in between. It releases the acknowledge once completion is seen, and it raises the acknowledge at chosen clock offsets, so waits of zero, one and several periods occur for every phase length.

// File: rtl/hsk_bus_pkg.sv
package hsk_bus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_P0, ST_P1, ST_P2, ST_P3, ST_P4, ST_P5, ST_P6, ST_P7
  } bus_st_e;
endpackage

// File: rtl/hsk_ack_sync.sv
module hsk_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic ack_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], ack_i};
  end

  assign ack_o = sync_q[STAGES-1];
endmodule

// File: rtl/hsk_phase_timer.sv
module hsk_phase_timer #(
  parameter int LEN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || last_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= len_i) else $error("phase counter overran"); // R2
endmodule

// File: rtl/hsk_bus_fsm.sv
module hsk_bus_fsm
  import hsk_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              ack_i,
  output bus_st_e           state_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  bus_st_e           state_q, state_d;
  logic              ack_d_q;
  logic [ADDR_W-1:0] cap_addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i)  state_d = ST_P0;
      ST_P0:   if (last_i) state_d = ST_P1;
      ST_P1:   if (last_i) state_d = ST_P2;
      ST_P2:   if (last_i) state_d = ST_P3;
      ST_P3:   if (last_i) state_d = ST_P4;
      ST_P4:   if (last_i && ack_d_q) state_d = ST_P5; // else one more wait period
      ST_P5:   if (last_i) state_d = ST_P6;
      ST_P6:   if (last_i) state_d = ST_P7;
      ST_P7:   if (last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ack_d_q    <= 1'b0;
      cap_addr_q <= '0;
      we_o       <= 1'b0;
      wdata_o    <= '0;
      addr_o     <= '0;
      rdata_o    <= '0;
      done_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_d_q <= ack_i;  // one clock of setup margin before the P4 exit edge
      done_o  <= (state_q == ST_P7) && last_i;
      if (state_q == ST_IDLE && req_i) begin
        cap_addr_q <= addr_i;
        we_o       <= we_i;
        wdata_o    <= wdata_i;
      end
      if (state_q == ST_P0 && last_i) addr_o <= cap_addr_q;
      if (state_q == ST_P6 && last_i && !we_o) rdata_o <= data_i;
    end
  end

  assign state_o = state_q;

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_P4 && last_i && !ack_d_q) |=> state_q == ST_P4) else $error("left P4 early"); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done longer than one clock"); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(cap_addr_q)) else $error("request taken while busy"); // R10
endmodule

// File: rtl/hsk_bus_master.sv
module hsk_bus_master
  import hsk_bus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LEN_W-1:0]  phase_len_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              addr_stb_o,
  output logic              data_stb_o,
  output logic              rd_nwr_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  bus_st_e state;
  logic    we, last, ack_sync;

  hsk_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .ack_o(ack_sync)
  );

  hsk_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(state != ST_IDLE),
    .len_i (phase_len_i), .last_o(last)
  );

  hsk_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i  (clk_i),  .rst_ni (rst_ni), .req_i  (req_i),   .we_i   (we_i),
    .addr_i (addr_i), .wdata_i(wdata_i), .data_i (data_i), .last_i (last),
    .ack_i  (ack_sync), .state_o(state), .we_o  (we),      .addr_o (addr_o),
    .wdata_o(data_o), .rdata_o(rdata_o), .done_o (done_o)
  );

  assign addr_stb_o = state inside {ST_P2, ST_P3, ST_P4, ST_P5, ST_P6};
  assign data_stb_o = state inside {ST_P4, ST_P5, ST_P6};
  assign rd_nwr_o   = !(we && (state inside {ST_P2, ST_P3, ST_P4, ST_P5, ST_P6, ST_P7}));
  assign data_oe_o  = we && (state inside {ST_P3, ST_P4, ST_P5, ST_P6, ST_P7});

  AST_STB_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_stb_o |-> addr_stb_o) else $error("data strobe without address strobe"); // R4
  AST_OE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !rd_nwr_o) else $error("driving bus in read"); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_stb_o && $past(addr_stb_o)) |-> $stable(addr_o)) else $error("address moved under strobe"); // R3
  AST_RW_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rd_nwr_o) else $error("direction not restored"); // R5
endmodule

// File: tb/hsk_bus_master_tb.sv
`timescale 1ns/1ps
module hsk_bus_master_tb;
  localparam int AW = 16, DW = 8, LW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, ack = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, din = '0;
  logic [LW-1:0] plen = '0;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o, rdata_o;
  logic oe, astb, dstb, rdnwr, done;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  hsk_bus_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .phase_len_i(plen), .ack_i(ack), .data_i(din),
    .addr_o(addr_o), .data_o(data_o), .data_oe_o(oe), .addr_stb_o(astb),
    .data_stb_o(dstb), .rd_nwr_o(rdnwr), .done_o(done), .rdata_o(rdata_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_txn(input int l, input bit w, input int c, input bit probe);
    int k, n_as, n_ds, n_rw, n_oe, f_as, f_ds, f_rw, f_oe, done_n, bad_a, bad_d, after;
    logic [AW-1:0] a;
    logic [DW-1:0] rv;
    k = 1;
    while ((4 + k) * l - 3 < c) k++;
    a  = AW'(16'h1000 + l * 257 + c * 13 + w);
    rv = DW'(l * 29 + c * 7 + 8'h5a);
    n_as = 0; n_ds = 0; n_rw = 0; n_oe = 0;
    f_as = 0; f_ds = 0; f_rw = 0; f_oe = 0;
    done_n = 0; bad_a = 0; bad_d = 0; after = 0;
    repeat (3) @(negedge clk);
    plen = LW'(l - 1); we = w; addr = a; wdata = ~rv; din = rv; req = 1;
    for (int n = 1; n <= 300; n++) begin
      @(negedge clk);
      if (n == 1) req = 0;
      if (n == c) ack = 1;
      if (n == (6 + k) * l + 1) din = ~rv;
      if (probe && n == 10) begin req = 1; addr = ~a; end
      if (probe && n == 11) begin req = 0; addr = a; end
      if (astb) begin n_as++; if (f_as == 0) f_as = n; if (addr_o != a) bad_a++; end
      if (dstb) begin n_ds++; if (f_ds == 0) f_ds = n; end
      if (!rdnwr) begin n_rw++; if (f_rw == 0) f_rw = n; end
      if (oe) begin n_oe++; if (f_oe == 0) f_oe = n; if (data_o != ~rv) bad_d++; end
      if (done) begin done_n = n; break; end
    end
    ack = 0;
    chk(done_n == (7 + k) * l + 1, "R7 done timing", done_n, (7 + k) * l + 1);
    chk(f_as == 2 * l + 1, "R2 addr strobe start", f_as, 2 * l + 1);
    chk(f_ds == 4 * l + 1, "R2 data strobe start", f_ds, 4 * l + 1);
    chk(n_as == (k + 4) * l, "R4 addr strobe width", n_as, (k + 4) * l);
    chk(n_ds == (k + 2) * l, "R7 data strobe width with waits", n_ds, (k + 2) * l);
    chk(bad_a == 0, "R3 address value", bad_a, 0);
    if (w) begin
      chk(f_rw == 2 * l + 1 && n_rw == (k + 5) * l, "R5 write direction", n_rw, (k + 5) * l);
      chk(f_oe == 3 * l + 1 && n_oe == (k + 4) * l, "R6 write enable", n_oe, (k + 4) * l);
      chk(bad_d == 0, "R6 write data", bad_d, 0);
    end else begin
      chk(n_rw == 0, "R5 read direction", n_rw, 0);
      chk(n_oe == 0, "R6 read enable", n_oe, 0);
      chk(rdata_o == rv, "R8 read capture", rdata_o, rv);
    end
    chk(rdnwr == 1'b1, "R5 direction restored", rdnwr, 1);
    @(negedge clk);
    chk(!done, "R9 done single clock", done, 0);
    if (!w) chk(rdata_o == rv, "R9 read data held", rdata_o, rv);
    if (probe) begin
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (astb || done) after++;
      end
      chk(after == 0, "R10 busy request ignored", after, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!astb && !dstb && !oe && !done, "R1 reset outputs low", {astb, dstb, oe, done}, 0);
    chk(rdnwr == 1'b1, "R1 reset direction", rdnwr, 1);
    rst_n = 1'b1;
    for (int l = 1; l <= 4; l++)
      for (int w = 0; w <= 1; w++) begin
        run_txn(l, w[0], 1, 1'b0);
        run_txn(l, w[0], 4 * l, 1'b0);
        run_txn(l, w[0], 5 * l - 2, 1'b0);
        run_txn(l, w[0], 5 * l, 1'b0);
        run_txn(l, w[0], 6 * l + 1, 1'b0);
      end
    run_txn(2, 1'b0, 1, 1'b1);
    run_txn(2, 1'b1, 3, 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule